// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of phase samples into instantaneous frequency. Each accepted phase word is an unsigned fraction of one full turn. It is first scaled by 1, 2, 4 or 8 modulo a full turn, which folds CW, BPSK, QPSK or 8PSK symbol phases onto one point and so removes the data modulation. The block then subtracts the scaled phase that arrived a programmable number of samples earlier. The 18-bit difference wraps modulo a full turn and is read as two's complement. It is rounded to a 16-bit signed frequency sample.

Scaled phases are kept in a short history line. The lag field picks which entry the current sample is differenced against. A sample is only produced once the history holds enough entries for the selected lag. Clearing the enable bit empties the history and silences the output. The producer of the phase and any filter after the block are outside it.

Top module: `phase_freq_disc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `freq_vld` is 0 and `freq_out` is 0.
- R2: With lag field 0 and multiplier code 00, an accepted sample p[k] produces `freq_out` = round(p[k] - p[k-1]).
- R3: Multiplier code 00/01/10/11 multiplies the phase by 1/2/4/8. This is a left shift of the 18-bit word that discards the bits shifted out. Both the current sample and the stored samples are scaled, because the history stores scaled values.
- R4: A lag field value n (0..7) differences the current sample against the scaled sample accepted n+1 samples earlier.
- R5: The difference is taken modulo 2^18 and read as two's complement. For example, 0x3FFF0 followed by 0x00010 gives +0x20 before rounding.
- R6: Rounding takes the 18-bit difference d and forms `freq_out` = bits 17:2 of (d + 2) mod 2^18. So d = 1 gives 0, d = 2 gives 1, and d = -3 gives -1.
- R7: `freq_vld` pulses for exactly one cycle. That cycle is the one after the clock edge at which an input is accepted (`phase_vld` and `cfg_enable` both high) and produces output. With no accepted input, `freq_vld` is 0.
- R8: After reset, or after the enable bit is set again, the first n+1 accepted samples produce no output.
- R9: While `cfg_enable` is 0, inputs are ignored, `freq_vld` is 0 and the history is emptied.
- R10: `freq_out` holds its value in every cycle in which `freq_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Discriminator on (1) or off (0) |
| cfg_mult | input | 2 | Phase multiplier code (00 x1, 01 x2, 10 x4, 11 x8) |
| cfg_lag | input | 3 | Lag select, n gives n+1 samples |
| phase_in | input | 18 | Unsigned phase, fraction of a full turn |
| phase_vld | input | 1 | Phase sample strobe |
| freq_out | output | 16 | Signed frequency sample |
| freq_vld | output | 1 | Frequency sample strobe |

## Verification
The assertions check several rules on every cycle: output never appears without an enabled input strobe on the previous edge, `freq_out` never moves while `freq_vld` is low, and the block stays silent while disabled. They also check the lag-one CW result against the two previous inputs. Only the bench scenarios can show the effects that depend on history: the fill delay after reset or re-enable for each lag value, the history being cleared by disable, the matching of samples that arrived up to eight samples back, and the 8PSK folding that collapses symbol phases to zero.

// File: rtl/phase_freq_disc_pkg.sv
package phase_freq_disc_pkg;
    typedef enum logic [1:0] {
        MUL_X1 = 2'b00,
        MUL_X2 = 2'b01,
        MUL_X4 = 2'b10,
        MUL_X8 = 2'b11
    } mul_code_e;
endpackage

// File: rtl/phase_scaler.sv
module phase_scaler #(
    parameter int PHASE_W = 18,
    parameter int MUL_W   = 2
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [MUL_W-1:0]   mul_i,
    output logic [PHASE_W-1:0] scaled_o
);
    // Modulo-turn multiply: bits shifted past the MSB are whole turns.
    always_comb begin
        scaled_o = phase_i << mul_i;
    end
endmodule

// File: rtl/lag_line.sv
module lag_line #(
    parameter int W     = 18,
    parameter int LAG_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             push_i,
    input  logic [W-1:0]     din_i,
    input  logic [LAG_W-1:0] sel_i,
    output logic [W-1:0]     tap_o,
    output logic [LAG_W:0]   fill_o
);
    localparam int DEPTH = 1 << LAG_W;
    localparam logic [LAG_W:0] FULL = (LAG_W+1)'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] hist;
        logic [LAG_W:0]          fill;
    } line_t;

    line_t line_d, line_q;

    always_comb begin
        line_d = line_q;
        if (clear_i) begin
            line_d = '0;
        end else if (push_i) begin
            line_d.hist[0] = din_i;
            for (int i = 1; i < DEPTH; i++) begin
                line_d.hist[i] = line_q.hist[i-1];
            end
            if (line_q.fill != FULL) begin
                line_d.fill = line_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
        end else begin
            line_q <= line_d;
        end
    end

    assign tap_o  = line_q.hist[sel_i];
    assign fill_o = line_q.fill;
endmodule

// File: rtl/diff_rounder.sv
module diff_rounder #(
    parameter int IN_W  = 18,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  cur_i,
    input  logic [IN_W-1:0]  old_i,
    output logic [OUT_W-1:0] rnd_o
);
    localparam int DROP = IN_W - OUT_W;
    localparam logic [IN_W-1:0] HALF = IN_W'(1) << (DROP - 1);

    logic [IN_W-1:0] diff;
    logic [IN_W-1:0] biased;

    always_comb begin
        diff   = cur_i - old_i;     // wraps modulo a full turn
        biased = diff + HALF;       // add half an output LSB, then truncate
        rnd_o  = biased[IN_W-1 -: OUT_W];
    end
endmodule

// File: rtl/phase_freq_disc.sv
module phase_freq_disc #(
    parameter int PHASE_W = 18,
    parameter int OUT_W   = 16,
    parameter int LAG_W   = 3,
    parameter int MUL_W   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_enable,
    input  logic [MUL_W-1:0]   cfg_mult,
    input  logic [LAG_W-1:0]   cfg_lag,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               phase_vld,
    output logic [OUT_W-1:0]   freq_out,
    output logic               freq_vld
);
    typedef struct packed {
        logic [OUT_W-1:0] freq;
        logic             vld;
    } out_t;

    out_t out_d, out_q;

    logic [PHASE_W-1:0] scaled;
    logic [PHASE_W-1:0] tap;
    logic [LAG_W:0]     fill;
    logic [OUT_W-1:0]   rnd;
    logic               accept;

    assign accept = cfg_enable & phase_vld;

    phase_scaler #(.PHASE_W(PHASE_W), .MUL_W(MUL_W)) u_scale (
        .phase_i (phase_in),
        .mul_i   (cfg_mult),
        .scaled_o(scaled)
    );

    lag_line #(.W(PHASE_W), .LAG_W(LAG_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(~cfg_enable),
        .push_i (accept),
        .din_i  (scaled),
        .sel_i  (cfg_lag),
        .tap_o  (tap),
        .fill_o (fill)
    );

    diff_rounder #(.IN_W(PHASE_W), .OUT_W(OUT_W)) u_rnd (
        .cur_i(scaled),
        .old_i(tap),
        .rnd_o(rnd)
    );

    always_comb begin
        out_d     = out_q;
        out_d.vld = 1'b0;
        if (accept && (fill > {1'b0, cfg_lag})) begin
            out_d.vld  = 1'b1;
            out_d.freq = rnd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign freq_out = out_q.freq;
    assign freq_vld = out_q.vld;
endmodule

// File: rtl/phase_freq_disc_chk.sv
module phase_freq_disc_chk #(
    parameter int PHASE_W = 18,
    parameter int OUT_W   = 16,
    parameter int LAG_W   = 3,
    parameter int MUL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cfg_enable,
    input logic [MUL_W-1:0]   cfg_mult,
    input logic [LAG_W-1:0]   cfg_lag,
    input logic [PHASE_W-1:0] phase_in,
    input logic               phase_vld,
    input logic [OUT_W-1:0]   freq_out,
    input logic               freq_vld
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    function automatic logic [OUT_W-1:0] ref_round(input logic [PHASE_W-1:0] a,
                                                  input logic [PHASE_W-1:0] b);
        logic [PHASE_W-1:0] t;
        t = a - b + (PHASE_W'(1) << (PHASE_W - OUT_W - 1));
        return t[PHASE_W-1 -: OUT_W];
    endfunction

    AST_VLD_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(phase_vld)) |-> !freq_vld); // R7

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(cfg_enable)) |-> !freq_vld); // R9

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !freq_vld) |-> $stable(freq_out)); // R10

    AST_LAG1_CW: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_vld && since_rst == 2'd3 && $past(phase_vld) && $past(phase_vld, 2)
         && $past(cfg_enable) && $past(cfg_enable, 2) && $past(cfg_lag) == '0
         && $past(cfg_mult) == '0 && $past(cfg_mult, 2) == '0)
        |-> freq_out == ref_round($past(phase_in), $past(phase_in, 2))); // R2

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!freq_vld && freq_out == '0)); // R1
endmodule

bind phase_freq_disc phase_freq_disc_chk #(
    .PHASE_W(PHASE_W), .OUT_W(OUT_W), .LAG_W(LAG_W), .MUL_W(MUL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mult(cfg_mult),
    .cfg_lag(cfg_lag), .phase_in(phase_in), .phase_vld(phase_vld),
    .freq_out(freq_out), .freq_vld(freq_vld)
);

// File: tb/sim_phase_freq_disc.sv
module sim_phase_freq_disc;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_enable;
    logic [1:0]  cfg_mult;
    logic [2:0]  cfg_lag;
    logic [17:0] phase_in;
    logic        phase_vld;
    logic [15:0] freq_out;
    logic        freq_vld;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    phase_freq_disc u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mult(cfg_mult),
        .cfg_lag(cfg_lag), .phase_in(phase_in), .phase_vld(phase_vld),
        .freq_out(freq_out), .freq_vld(freq_vld)
    );

    // Reference model state
    logic [17:0] m_hist [8];
    int          m_fill;
    logic [15:0] m_last;

    // vector: {enable, mult, lag, vld, phase}
    localparam int NV = 20;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 2'd0, 3'd0, 1'b1, 18'h01000},
        {1'b1, 2'd0, 3'd0, 1'b1, 18'h01400},
        {1'b1, 2'd0, 3'd0, 1'b0, 18'h3FFFF},
        {1'b1, 2'd0, 3'd0, 1'b1, 18'h01000},
        {1'b1, 2'd0, 3'd2, 1'b1, 18'h02000},
        {1'b1, 2'd0, 3'd2, 1'b1, 18'h02100},
        {1'b1, 2'd0, 3'd7, 1'b1, 18'h20000},
        {1'b1, 2'd0, 3'd7, 1'b1, 18'h20005},
        {1'b1, 2'd0, 3'd7, 1'b1, 18'h00003},
        {1'b1, 2'd0, 3'd7, 1'b1, 18'h3FF00},
        {1'b1, 2'd1, 3'd0, 1'b1, 18'h20010},
        {1'b1, 2'd1, 3'd0, 1'b1, 18'h00020},
        {1'b1, 2'd2, 3'd1, 1'b1, 18'h10003},
        {1'b1, 2'd2, 3'd1, 1'b1, 18'h30001},
        {1'b1, 2'd2, 3'd1, 1'b1, 18'h00007},
        {1'b1, 2'd3, 3'd0, 1'b1, 18'h08000},
        {1'b1, 2'd3, 3'd0, 1'b1, 18'h18000},
        {1'b1, 2'd3, 3'd0, 1'b1, 18'h38001},
        {1'b1, 2'd0, 3'd0, 1'b1, 18'h00002},
        {1'b1, 2'd0, 3'd0, 1'b1, 18'h3FFFF}
    };

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_hist[i] = '0;
        m_fill = 0;
    endtask

    task automatic fail(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_bad++;
        $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    endtask

    // One sample: drive at a falling edge, check at the next falling edge.
    task automatic step(input logic en, input logic [1:0] m, input logic [2:0] l,
                        input logic v, input logic [17:0] p, input string req);
        logic [17:0] sc, df;
        logic        e_vld;
        logic [15:0] e_out;
        cfg_enable = en; cfg_mult = m; cfg_lag = l; phase_vld = v; phase_in = p;
        sc    = p << m;
        e_vld = 1'b0;
        e_out = m_last;
        if (!en) begin
            model_reset();
        end else if (v) begin
            if (m_fill >= int'(l) + 1) begin
                df    = sc - m_hist[l] + 18'd2;
                e_vld = 1'b1;
                e_out = df[17:2];
            end
            for (int i = 7; i > 0; i--) m_hist[i] = m_hist[i-1];
            m_hist[0] = sc;
            if (m_fill < 8) m_fill++;
        end
        @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (freq_vld !== e_vld || freq_out !== e_out) begin
            fail(req, {15'd0, freq_vld, freq_out}, {15'd0, e_vld, e_out});
        end
        m_last = e_out;
    endtask

    task automatic expect_lit(input logic [15:0] exp, input string req);
        n_chk++;
        if (freq_vld !== 1'b1 || freq_out !== exp)
            fail(req, {15'd0, freq_vld, freq_out}, {16'd1, exp});
    endtask

    initial begin
        #(20 * 20000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_enable = 1'b0; cfg_mult = '0; cfg_lag = '0;
        phase_in = '0; phase_vld = 1'b0;
        m_last = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_chk++;
        if (freq_vld !== 1'b0 || freq_out !== 16'h0)
            fail("R1", {15'd0, freq_vld, freq_out}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        n_chk++;
        if (freq_vld !== 1'b0 || freq_out !== 16'h0)
            fail("R1", {15'd0, freq_vld, freq_out}, 32'd0);

        // Table walk: R2 R3 R4 R5 R6 R7 R8 R10
        for (int k = 0; k < NV; k++) begin
            step(VEC[k][24], VEC[k][23:22], VEC[k][21:19], VEC[k][18], VEC[k][17:0],
                 "R2/R3/R4/R7/R8/R10 table");
        end

        // R9: disable clears history and silences output
        step(1'b0, 2'd0, 3'd0, 1'b1, 18'h12345, "R9 disabled");
        step(1'b0, 2'd0, 3'd0, 1'b1, 18'h00100, "R9 disabled");
        // R8: refill after re-enable with lag 2 needs three samples
        step(1'b1, 2'd0, 3'd2, 1'b1, 18'h00100, "R8 refill");
        step(1'b1, 2'd0, 3'd2, 1'b1, 18'h00200, "R8 refill");
        step(1'b1, 2'd0, 3'd2, 1'b1, 18'h00300, "R8 refill");
        step(1'b1, 2'd0, 3'd2, 1'b1, 18'h00400, "R4 lag3");
        expect_lit(16'h00C0, "R4 lag3 literal");

        // R5: wrap across zero, literal +8
        step(1'b1, 2'd0, 3'd0, 1'b1, 18'h3FFF0, "R5 wrap");
        step(1'b1, 2'd0, 3'd0, 1'b1, 18'h00010, "R5 wrap");
        expect_lit(16'h0008, "R5 wrap literal");

        // R6: rounding boundaries d=1 ->0, d=2 ->1, d=-3 -> -1
        step(1'b1, 2'd0, 3'd0, 1'b1, 18'h00011, "R6 round");
        expect_lit(16'h0000, "R6 d=1");
        step(1'b1, 2'd0, 3'd0, 1'b1, 18'h00013, "R6 round");
        expect_lit(16'h0001, "R6 d=2");
        step(1'b1, 2'd0, 3'd0, 1'b1, 18'h00010, "R6 round");
        expect_lit(16'hFFFF, "R6 d=-3");

        // R3: 8PSK phases fold to zero under x8
        step(1'b1, 2'd3, 3'd0, 1'b1, 18'h08000, "R3 x8");
        step(1'b1, 2'd3, 3'd0, 1'b1, 18'h28000, "R3 x8");
        expect_lit(16'h0000, "R3 x8 fold literal");

        // R7/R10: idle cycles, no input means no output and held value
        step(1'b1, 2'd0, 3'd0, 1'b0, 18'h3AAAA, "R7/R10 idle");
        step(1'b1, 2'd1, 3'd5, 1'b0, 18'h15555, "R7/R10 idle");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule